// File: doc/BRIEF.md
# Encoder Input Conditioning Filter

This block conditions the three raw signals of an incremental position encoder: the two quadrature phases and the once-per-turn index. Each raw pin is brought into the module clock domain by a two-flop synchronizer. It is then gated by a per-channel enable and optionally inverted. A small state machine per channel removes short glitches. That machine only samples on a sample tick. The tick comes from a free-running pre-divider whose ratio is picked by a 3-bit code. A single control bit bypasses the filter.

The outputs are a clean level per channel and one-cycle rising and falling edge pulses, ready for a quadrature counter. Channel bit 0 is phase A, bit 1 is phase B and bit 2 is the index. The index-detected event is `rise_pls[2]`, which is the rising edge of the index after the inversion has been applied.

Each channel's filter state machine has six states. `F_LOW` and `F_HIGH` are the settled states. `F_LOW_Q1` and `F_LOW_Q2` count one and two high samples seen while the output is low. `F_HIGH_Q1` and `F_HIGH_Q2` count one and two low samples seen while the output is high. The transitions, taken on a sample tick, are as follows:
- A sample opposite to the output advances the machine `F_LOW`→`F_LOW_Q1`→`F_LOW_Q2`→`F_HIGH`, or `F_HIGH`→`F_HIGH_Q1`→`F_HIGH_Q2`→`F_LOW`.
- A sample equal to the output returns the machine to its settled state.
- A disabled channel forces the machine to `F_LOW` on every clock.
- Bypass forces the machine to `F_HIGH` or `F_LOW` on every clock, following the conditioned input.

Top module: `enc_input_cond`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, all `clean_lvl`, `rise_pls` and `fall_pls` bits are 0, and the pre-divider count is 0.
- R2: The sample divider D comes from `div_sel` as follows: 0→1, 1→2, 2→4, 3→16, 4→32, 5→64, and both 6 and 7→64. A counter starts at 0 after reset. It gives a sample tick on a clock whose count is at least D−1, and on that clock it returns to 0; otherwise it increments. With `div_sel`=0 there is a tick on every clock.
- R3: With the filter active, `clean_lvl` changes only after three consecutive sample ticks whose conditioned input differs from `clean_lvl`. It changes on the clock of the third such tick. A tick with an equal sample clears the run.
- R4: With `filt_bypass`=1, `clean_lvl` follows the conditioned input one clock after it. A raw change shows on `clean_lvl` after the third rising clock edge.
- R5: A channel with its `ch_en` bit at 0 has `clean_lvl` at 0 from the next clock on, and never raises `rise_pls` or `fall_pls`.
- R6: The conditioned input is the synchronized raw bit XOR the `ch_inv` bit, AND the `ch_en` bit.
- R7: `rise_pls[i]` is high for exactly the one clock after `clean_lvl[i]` has gone from 0 to 1, and only while `ch_en[i]`=1. `fall_pls[i]` does the same for a change from 1 to 0.
- R8: Each raw bit passes through two flops before it is conditioned. No raw change reaches `clean_lvl` before the third rising edge after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| raw_in | input | NUM_CH | Raw encoder pins (bit 0 A, bit 1 B, bit 2 index) |
| ch_en | input | NUM_CH | Per-channel enable |
| ch_inv | input | NUM_CH | Per-channel polarity inversion |
| filt_bypass | input | 1 | 1 = noise filter bypassed |
| div_sel | input | 3 | Sample pre-divider code |
| clean_lvl | output | NUM_CH | Filtered level per channel |
| rise_pls | output | NUM_CH | One-cycle rising-edge pulse per channel |
| fall_pls | output | NUM_CH | One-cycle falling-edge pulse per channel |

## Verification
A filter state machine stuck in a pending state, or one that keeps its run count across an equal sample, shows up as a `clean_lvl` change that is early, late or missing. It becomes visible within three sample periods of the input change, so within at most 192 clocks. A wrong divider or synchronizer depth shifts every level change by a fixed number of clocks, and this is seen at the first input edge after the setting. Wrong gating or inversion corrupts the level one clock after the conditioned input changes, and a stray or stretched edge pulse is seen on the clock after the level moves.

// File: rtl/enc_cond_pkg.sv
package enc_cond_pkg;

    typedef enum logic [2:0] {
        F_LOW     = 3'd0,
        F_LOW_Q1  = 3'd1,
        F_LOW_Q2  = 3'd2,
        F_HIGH    = 3'd4,
        F_HIGH_Q1 = 3'd5,
        F_HIGH_Q2 = 3'd6
    } filt_state_e;

    // R2: non-uniform divider ladder, codes above 5 saturate at the largest ratio
    function automatic int unsigned div_of_code(input logic [2:0] code);
        unique case (code)
            3'd0:    return 1;
            3'd1:    return 2;
            3'd2:    return 4;
            3'd3:    return 16;
            3'd4:    return 32;
            default: return 64;
        endcase
    endfunction

endpackage

// File: rtl/enc_sample_tick.sv
module enc_sample_tick #(
    parameter int unsigned MAX_DIV = 64,
    localparam int unsigned CNT_W  = $clog2(MAX_DIV)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] div_sel,
    output logic       tick
);
    import enc_cond_pkg::*;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;

    always_comb begin
        limit = CNT_W'(div_of_code(div_sel) - 1);
    end

    // >= keeps the counter bounded when the ratio is lowered mid-period
    assign tick = (cnt_q >= limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/enc_sync.sv
module enc_sync #(
    parameter int unsigned WIDTH  = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < int'(STAGES); s++) begin
                stage_q[s] <= '0;
            end
        end else begin
            stage_q[0] <= d;
            for (int s = 1; s < int'(STAGES); s++) begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/enc_chan_filter.sv
module enc_chan_filter (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic cond,
    input  logic bypass,
    input  logic tick,
    output logic lvl,
    output logic rise,
    output logic fall
);
    import enc_cond_pkg::*;

    filt_state_e state_q;
    filt_state_e state_d;
    logic        lvl_prev_q;

    // next-state selection
    always_comb begin
        unique case (state_q)
            F_LOW:     state_d = cond ? F_LOW_Q1 : F_LOW;
            F_LOW_Q1:  state_d = cond ? F_LOW_Q2 : F_LOW;
            F_LOW_Q2:  state_d = cond ? F_HIGH   : F_LOW;
            F_HIGH:    state_d = cond ? F_HIGH   : F_HIGH_Q1;
            F_HIGH_Q1: state_d = cond ? F_HIGH   : F_HIGH_Q2;
            F_HIGH_Q2: state_d = cond ? F_HIGH   : F_LOW;
            default:   state_d = F_LOW;
        endcase
        if (!en) begin
            state_d = F_LOW;
        end else if (bypass) begin
            state_d = cond ? F_HIGH : F_LOW;
        end else if (!tick) begin
            state_d = state_q;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= F_LOW;
            lvl_prev_q <= 1'b0;
        end else begin
            state_q    <= state_d;
            lvl_prev_q <= lvl;
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            F_HIGH, F_HIGH_Q1, F_HIGH_Q2: lvl = 1'b1;
            default:                      lvl = 1'b0;
        endcase
        rise = en &  lvl & ~lvl_prev_q;
        fall = en & ~lvl &  lvl_prev_q;
    end

endmodule

// File: rtl/enc_input_cond.sv
module enc_input_cond #(
    parameter int unsigned NUM_CH      = 3,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned MAX_DIV     = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] raw_in,
    input  logic [NUM_CH-1:0] ch_en,
    input  logic [NUM_CH-1:0] ch_inv,
    input  logic              filt_bypass,
    input  logic [2:0]        div_sel,
    output logic [NUM_CH-1:0] clean_lvl,
    output logic [NUM_CH-1:0] rise_pls,
    output logic [NUM_CH-1:0] fall_pls
);
    logic [NUM_CH-1:0] raw_sync;
    logic [NUM_CH-1:0] cond;
    logic              samp_tick;

    enc_sync #(
        .WIDTH (NUM_CH),
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (raw_in),
        .q    (raw_sync)
    );

    enc_sample_tick #(
        .MAX_DIV(MAX_DIV)
    ) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .div_sel(div_sel),
        .tick   (samp_tick)
    );

    assign cond = ch_en & (raw_sync ^ ch_inv);

    for (genvar c = 0; c < int'(NUM_CH); c++) begin : g_ch
        enc_chan_filter u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (ch_en[c]),
            .cond  (cond[c]),
            .bypass(filt_bypass),
            .tick  (samp_tick),
            .lvl   (clean_lvl[c]),
            .rise  (rise_pls[c]),
            .fall  (fall_pls[c])
        );
    end

endmodule

// File: rtl/enc_input_cond_chk.sv
module enc_input_cond_chk #(
    parameter int unsigned NUM_CH = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CH-1:0] ch_en,
    input logic              filt_bypass,
    input logic [2:0]        div_sel,
    input logic              samp_tick,
    input logic [NUM_CH-1:0] clean_lvl,
    input logic [NUM_CH-1:0] rise_pls,
    input logic [NUM_CH-1:0] fall_pls
);
    a_r2_tick_every_clock: assert property (@(posedge clk) disable iff (!rst_n)
        (div_sel == 3'd0) |-> samp_tick);

    for (genvar c = 0; c < int'(NUM_CH); c++) begin : g_ch
        a_r7_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
            rise_pls[c] |=> !rise_pls[c]);
        a_r7_fall_single: assert property (@(posedge clk) disable iff (!rst_n)
            fall_pls[c] |=> !fall_pls[c]);
        a_r7_rise_follows_level: assert property (@(posedge clk) disable iff (!rst_n)
            rise_pls[c] |-> (clean_lvl[c] && !fall_pls[c]));
        a_r5_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            !ch_en[c] |-> (!rise_pls[c] && !fall_pls[c]));
        a_r5_disabled_low: assert property (@(posedge clk) disable iff (!rst_n)
            !ch_en[c] |=> !clean_lvl[c]);
        a_r3_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_en[c] && !filt_bypass && !samp_tick) |=> $stable(clean_lvl[c]));
    end

endmodule

bind enc_input_cond enc_input_cond_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ch_en      (ch_en),
    .filt_bypass(filt_bypass),
    .div_sel    (div_sel),
    .samp_tick  (samp_tick),
    .clean_lvl  (clean_lvl),
    .rise_pls   (rise_pls),
    .fall_pls   (fall_pls)
);

// File: tb/enc_input_cond_tb.sv
`timescale 1ns/1ps
module enc_input_cond_tb;
    localparam int NCH = 3;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NCH-1:0] raw_in = '0;
    logic [NCH-1:0] ch_en = '0;
    logic [NCH-1:0] ch_inv = '0;
    logic           filt_bypass = 1'b0;
    logic [2:0]     div_sel = 3'd0;
    logic [NCH-1:0] clean_lvl, rise_pls, fall_pls;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // reference state
    int             m_cnt = 0;
    logic [NCH-1:0] m_s1 = '0, m_s2 = '0, m_lvl = '0, m_prev = '0;
    int             m_run [NCH];

    always #10 clk = ~clk;

    enc_input_cond u_dut (
        .clk(clk), .rst_n(rst_n), .raw_in(raw_in), .ch_en(ch_en), .ch_inv(ch_inv),
        .filt_bypass(filt_bypass), .div_sel(div_sel),
        .clean_lvl(clean_lvl), .rise_pls(rise_pls), .fall_pls(fall_pls)
    );

    function automatic int bench_div(input logic [2:0] code);
        case (code)
            3'd0: return 1;
            3'd1: return 2;
            3'd2: return 4;
            3'd3: return 16;
            3'd4: return 32;
            default: return 64;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic string mode_tag(input int c);
        if (!ch_en[c])   return "R5";
        if (filt_bypass) return "R4 R6 R8";
        return "R2 R3 R6 R8";
    endfunction

    // reference update for one rising edge, using the inputs present at the edge
    task automatic model_edge();
        bit tk;
        tk = (m_cnt >= bench_div(div_sel) - 1);
        m_cnt = tk ? 0 : m_cnt + 1;
        for (int c = 0; c < NCH; c++) begin
            logic cd;
            cd = ch_en[c] & (m_s2[c] ^ ch_inv[c]);
            m_prev[c] = m_lvl[c];
            if (!ch_en[c]) begin
                m_lvl[c] = 1'b0; m_run[c] = 0;
            end else if (filt_bypass) begin
                m_lvl[c] = cd; m_run[c] = 0;
            end else if (tk) begin
                if (cd != m_lvl[c]) begin
                    m_run[c]++;
                    if (m_run[c] == 3) begin m_lvl[c] = cd; m_run[c] = 0; end
                end else begin
                    m_run[c] = 0;
                end
            end
        end
        m_s2 = m_s1;
        m_s1 = raw_in;
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        #2;
        for (int c = 0; c < NCH; c++) begin
            check({mode_tag(c), " level"}, 32'(clean_lvl[c]), 32'(m_lvl[c]));
            check({"R7 ", mode_tag(c), " rise"}, 32'(rise_pls[c]),
                  32'(ch_en[c] & m_lvl[c] & ~m_prev[c]));
            check({"R7 ", mode_tag(c), " fall"}, 32'(fall_pls[c]),
                  32'(ch_en[c] & ~m_lvl[c] & m_prev[c]));
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int hold;
        void'($urandom(32'd4711));
        for (int c = 0; c < NCH; c++) m_run[c] = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 level in reset", 32'(clean_lvl), 32'd0);
        check("R1 pulses in reset", 32'(rise_pls | fall_pls), 32'd0);
        rst_n = 1'b1;
        ch_en = 3'b111;
        step();
        check("R1 level after release", 32'(clean_lvl), 32'd0);

        // R4/R8: bypass latency from raw edge is three rising edges
        filt_bypass = 1'b1;
        repeat (4) step();
        raw_in = 3'b001;
        begin
            int lat = 0;
            for (int k = 1; k <= 8; k++) begin
                step();
                if (clean_lvl[0] && lat == 0) lat = k;
            end
            check("R4 R8 bypass latency", 32'(lat), 32'd3);
        end

        // R6: inversion of a low raw index gives a high level
        raw_in = 3'b000; ch_inv = 3'b100;
        repeat (5) step();
        check("R6 inverted index level", 32'(clean_lvl[2]), 32'd1);
        ch_inv = 3'b000;
        repeat (5) step();

        // R3: a two-sample glitch at /1 is rejected
        filt_bypass = 1'b0; div_sel = 3'd0;
        repeat (6) step();
        raw_in = 3'b010;
        repeat (2) step();
        raw_in = 3'b000;
        begin
            bit moved = 1'b0;
            for (int k = 0; k < 10; k++) begin
                step();
                if (clean_lvl[1]) moved = 1'b1;
            end
            check("R3 glitch rejected", 32'(moved), 32'd0);
        end

        // random segments over every divider code, bypass and enable patterns
        for (int seg = 0; seg < 12; seg++) begin
            div_sel     = (seg < 8) ? 3'(seg) : 3'($urandom % 8);
            filt_bypass = (seg >= 8) && (seg % 2 == 0);
            ch_en       = 3'($urandom) | 3'b001;
            ch_inv      = 3'($urandom);
            hold = 0;
            for (int n = 0; n < 1500; n++) begin
                if (hold == 0) begin
                    raw_in = 3'($urandom);
                    hold = 1 + int'($urandom % (bench_div(div_sel) * 5));
                end
                hold--;
                if ($urandom % 300 == 0) ch_en = ch_en ^ 3'(1 << ($urandom % 3));
                step();
            end
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule